// File: doc/BRIEF.md
# Per-lane floating-point result memo table

This block sits beside one lane's pipelined single-precision arithmetic unit. It holds a small set of recently completed operations: opcode, both operands and the result. Each entry was produced with no timing error. When an instruction is issued, its opcode and operands are compared with every stored entry in the issue cycle. On a match the stored result is carried down a side shift register that runs alongside the pipeline, and the arithmetic unit's clock enable is held low for that operation, so the unit does not compute it.

When an instruction completes, the pipeline's timing-error flag is resolved against the hit decision. A miss with no error stores the new result and overwrites the oldest entry once the table is full. A miss with an error raises a replay request to the external error-control logic. A hit uses the stored result in either case, so an error flag raised on a hit is dropped. A one-bit configuration register selects exact or approximate comparison. Approximate comparison ignores the low 12 bits of each operand. Writing the register empties the table. The arithmetic unit is a fixed-latency behavioural stand-in with a simple integer function per opcode.

Top module: `fpu_memo_lane`

## Requirements
- R1: After reset the table is empty, `out_valid` and `replay_req` are low, and the first issued instruction misses.
- R2: An issued instruction completes on `out_valid` exactly 4 cycles after its issue cycle. On a miss, `out_from_memo` is 0 and `out_result` is the stand-in result: op 0 a+b, op 1 a-b, op 2 a^b, op 3 a&b, any other op a|b (32-bit integer arithmetic).
- R3: A miss that completes with `pipe_err` low is stored. A later issue with the same opcode and operands hits, with `out_from_memo` = 1 and the stored result.
- R4: In an issue cycle, `fpu_clk_en` is 1 on a miss and 0 on a hit. It is 0 when `iss_valid` is low.
- R5: A miss that completes with `pipe_err` high raises `replay_req` in its completion cycle and is not stored, so reissuing it misses.
- R6: A hit that completes with `pipe_err` high returns the stored result and leaves `replay_req` low.
- R7: In exact mode (`cfg_wdata` = 0 written) operands that differ in bit 0 do not match.
- R8: In approximate mode (`cfg_wdata` = 1 written) operands that differ only in bits 11:0 match and return the stored result. A difference in bit 12, or a different opcode, does not match.
- R9: The table holds 4 entries. A fifth store evicts the oldest entry and keeps the other four.
- R10: A configuration write (`cfg_we` = 1) invalidates every entry.
- R11: `out_valid` and `replay_req` are low in cycles where no instruction completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Instruction issued this cycle |
| iss_op | input | 3 | Opcode of issued instruction |
| iss_a | input | 32 | First operand |
| iss_b | input | 32 | Second operand |
| pipe_err | input | 1 | Timing-error flag of the instruction completing this cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 1 | Matching mode: 1 approximate, 0 exact |
| out_valid | output | 1 | A result completes this cycle |
| out_result | output | 32 | Completed result |
| out_from_memo | output | 1 | Result source: 1 table, 0 pipeline |
| fpu_clk_en | output | 1 | Clock enable for the arithmetic unit in the issue cycle |
| replay_req | output | 1 | Replay request to the error-control logic |

## Verification
The hardest case to reach is a timing error on an instruction that hits. It requires a stored entry, a matching reissue, and `pipe_err` driven in exactly that instruction's completion cycle, four cycles after issue. The bench fills an entry with an error-free miss, reissues the same operands, and raises the flag only in the counted completion cycle. Eviction order is reached by storing five distinct operations one at a time. The four newest are probed first and the oldest last, so that the probes cannot disturb the contents under test.

// File: rtl/fml_pkg.sv
package fml_pkg;
  localparam int DW  = 32;
  localparam int OPW = 3;

  typedef logic [DW-1:0]  word_t;
  typedef logic [OPW-1:0] opc_t;

  typedef struct packed {
    opc_t  op;
    word_t a;
    word_t b;
  } key_t;

  typedef struct packed {
    key_t  key;
    word_t res;
  } entry_t;

  // side-band carried beside the pipeline
  typedef struct packed {
    logic  hit;
    word_t mres;
    key_t  key;
  } tag_t;
endpackage

// File: rtl/fml_stub_fpu.sv
module fml_stub_fpu
  import fml_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  key_t  key,
  output logic  vld_o,
  output word_t res_o
);
  logic [LAT-1:0] vld_q;
  word_t          res_q [LAT];
  word_t          calc;

  // behavioural stand-in for the arithmetic function
  always_comb begin
    case (key.op)
      3'd0:    calc = key.a + key.b;
      3'd1:    calc = key.a - key.b;
      3'd2:    calc = key.a ^ key.b;
      3'd3:    calc = key.a & key.b;
      default: calc = key.a | key.b;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= {vld_q[LAT-2:0], en};
  end

  // data stages are clock-enabled by the valid ahead of them
  always_ff @(posedge clk) begin
    if (en) res_q[0] <= calc;
    for (int i = 1; i < LAT; i++) begin
      if (vld_q[i-1]) res_q[i] <= res_q[i-1];
    end
  end

  assign vld_o = vld_q[LAT-1];
  assign res_o = res_q[LAT-1];
endmodule

// File: rtl/fml_align.sv
module fml_align
  import fml_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld_i,
  input  tag_t tag_i,
  output logic vld_o,
  output tag_t tag_o
);
  logic [LAT-1:0] vld_q;
  tag_t           tag_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= {vld_q[LAT-2:0], vld_i};
  end

  always_ff @(posedge clk) begin
    if (vld_i) tag_q[0] <= tag_i;
    for (int i = 1; i < LAT; i++) begin
      if (vld_q[i-1]) tag_q[i] <= tag_q[i-1];
    end
  end

  assign vld_o = vld_q[LAT-1];
  assign tag_o = tag_q[LAT-1];
endmodule

// File: rtl/fml_memo_table.sv
module fml_memo_table
  import fml_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IGN   = 12
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  approx,
  input  logic  flush,
  input  key_t  look_key,
  output logic  hit,
  output word_t hit_res,
  input  logic  push,
  input  key_t  push_key,
  input  word_t push_res
);
  localparam int    PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam word_t AMASK = {{(DW-IGN){1'b1}}, {IGN{1'b0}}};

  logic [DEPTH-1:0] vld_q, vld_d, match;
  logic [PW-1:0]    wp_q, wp_d;
  entry_t           ent_q [DEPTH];
  word_t            cmask;

  assign cmask = approx ? AMASK : '1;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = vld_q[i]
                   && (ent_q[i].key.op == look_key.op)
                   && (((ent_q[i].key.a ^ look_key.a) & cmask) == '0)
                   && (((ent_q[i].key.b ^ look_key.b) & cmask) == '0);
  end

  always_comb begin
    hit     = 1'b0;
    hit_res = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_res = ent_q[i].res;
      end
    end
  end

  // next state: valid bits and round-robin write pointer (oldest slot)
  always_comb begin
    vld_d = vld_q;
    wp_d  = wp_q;
    if (flush) begin
      vld_d = '0;
      wp_d  = '0;
    end else if (push) begin
      vld_d[wp_q] = 1'b1;
      wp_d        = (wp_q == PW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      wp_q  <= '0;
    end else begin
      vld_q <= vld_d;
      wp_q  <= wp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) ent_q[wp_q] <= '{key: push_key, res: push_res};
  end

  a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0));
  a_r9_full_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    ((&vld_q) && push && !flush) |=> (&vld_q));
  a_r1_hit_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (vld_q != '0));
endmodule

// File: rtl/fpu_memo_lane.sv
module fpu_memo_lane
  import fml_pkg::*;
#(
  parameter int LAT   = 4,
  parameter int DEPTH = 4,
  parameter int IGN   = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [OPW-1:0] iss_op,
  input  logic [DW-1:0] iss_a,
  input  logic [DW-1:0] iss_b,
  input  logic          pipe_err,
  input  logic          cfg_we,
  input  logic          cfg_wdata,
  output logic          out_valid,
  output logic [DW-1:0] out_result,
  output logic          out_from_memo,
  output logic          fpu_clk_en,
  output logic          replay_req
);
  logic [1:0] rs_q;
  logic       rst_ni;
  logic       approx_q;
  key_t       iss_key;
  logic       lk_hit;
  word_t      lk_res;
  logic       cmp_vld;
  tag_t       cmp_tag;
  logic       pipe_vld;
  word_t      pipe_res;
  logic       push;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     approx_q <= 1'b0;
    else if (cfg_we) approx_q <= cfg_wdata;
  end

  assign iss_key = '{op: iss_op, a: iss_a, b: iss_b};

  fml_memo_table #(.DEPTH(DEPTH), .IGN(IGN)) u_tab (
    .clk(clk), .rst_n(rst_ni), .approx(approx_q), .flush(cfg_we),
    .look_key(iss_key), .hit(lk_hit), .hit_res(lk_res),
    .push(push), .push_key(cmp_tag.key), .push_res(pipe_res)
  );

  assign fpu_clk_en = iss_valid & ~lk_hit;

  fml_stub_fpu #(.LAT(LAT)) u_fpu (
    .clk(clk), .rst_n(rst_ni), .en(fpu_clk_en), .key(iss_key),
    .vld_o(pipe_vld), .res_o(pipe_res)
  );

  fml_align #(.LAT(LAT)) u_aln (
    .clk(clk), .rst_n(rst_ni), .vld_i(iss_valid),
    .tag_i('{hit: lk_hit, mres: lk_res, key: iss_key}),
    .vld_o(cmp_vld), .tag_o(cmp_tag)
  );

  // completion: resolve hit decision against the error flag
  always_comb begin
    out_valid     = cmp_vld;
    out_from_memo = cmp_vld & cmp_tag.hit;
    out_result    = '0;
    if (cmp_vld) out_result = cmp_tag.hit ? cmp_tag.mres : pipe_res;
    replay_req    = cmp_vld & ~cmp_tag.hit & pipe_err;
    push          = cmp_vld & ~cmp_tag.hit & ~pipe_err;
  end

  a_r2_pipe_lines_up: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmp_vld && !cmp_tag.hit) |-> pipe_vld);
  a_r3_no_compute_on_hit: assert property (@(posedge clk) disable iff (!rst_ni)
    pipe_vld |-> (cmp_vld && !cmp_tag.hit));
  a_r6_error_masked: assert property (@(posedge clk) disable iff (!rst_ni)
    out_from_memo |-> !replay_req);
  a_r11_replay_only_on_completion: assert property (@(posedge clk) disable iff (!rst_ni)
    replay_req |-> out_valid);
endmodule

// File: tb/tb_fpu_memo_lane.sv
module tb_fpu_memo_lane;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_valid, pipe_err, cfg_we, cfg_wdata;
  logic [2:0]  iss_op;
  logic [31:0] iss_a, iss_b;
  logic        out_valid, out_from_memo, fpu_clk_en, replay_req;
  logic [31:0] out_result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  fpu_memo_lane dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_a(iss_a), .iss_b(iss_b), .pipe_err(pipe_err), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_result(out_result),
    .out_from_memo(out_from_memo), .fpu_clk_en(fpu_clk_en), .replay_req(replay_req)
  );

  function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      3'd0:    return a + b;
      3'd1:    return a - b;
      3'd2:    return a ^ b;
      3'd3:    return a & b;
      default: return a | b;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // one instruction, issued and followed to completion
  task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input bit err, input bit exp_hit, input logic [31:0] exp_res, input string req);
    @(negedge clk);
    iss_valid = 1'b1; iss_op = op; iss_a = a; iss_b = b;
    #1;
    check(fpu_clk_en == !exp_hit, {req, " R4 clock enable"}, 32'(fpu_clk_en), 32'(!exp_hit));
    @(negedge clk);
    iss_valid = 1'b0;
    #1;
    check(fpu_clk_en == 1'b0, "R4 idle clock enable", 32'(fpu_clk_en), 32'd0);
    repeat (2) @(negedge clk);
    @(negedge clk);
    pipe_err = err;
    #1;
    check(out_valid == 1'b1, {req, " R2 completion"}, 32'(out_valid), 32'd1);
    check(out_from_memo == exp_hit, {req, " source"}, 32'(out_from_memo), 32'(exp_hit));
    check(out_result == exp_res, {req, " result"}, out_result, exp_res);
    check(replay_req == (err && !exp_hit), {req, " replay"}, 32'(replay_req), 32'(err && !exp_hit));
    @(negedge clk);
    pipe_err = 1'b0;
    #1;
    check(out_valid == 1'b0 && replay_req == 1'b0, "R11 quiet after completion",
          32'({out_valid, replay_req}), 32'd0);
  endtask

  task automatic cfg_write(input bit mode);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = mode;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
    check(replay_req == 1'b0, "R1 replay after reset", 32'(replay_req), 32'd0);
    run_op(3'd0, 32'h0000_1234, 32'h0000_0001, 1'b0, 1'b0, 32'h0000_1235, "R1 first issue misses");
  endtask

  task automatic t_miss_then_hit();
    run_op(3'd1, 32'h1000_0000, 32'h0000_0001, 1'b0, 1'b0, 32'h0FFF_FFFF, "R2 miss sub");
    run_op(3'd1, 32'h1000_0000, 32'h0000_0001, 1'b0, 1'b1, 32'h0FFF_FFFF, "R3 hit sub");
    run_op(3'd4, 32'hF0F0_0000, 32'h0000_0F0F, 1'b0, 1'b0, 32'hF0F0_0F0F, "R2 miss or");
  endtask

  task automatic t_miss_error();
    run_op(3'd2, 32'hAAAA_5555, 32'hFFFF_0000, 1'b1, 1'b0, 32'h5555_5555, "R5 miss with error");
    run_op(3'd2, 32'hAAAA_5555, 32'hFFFF_0000, 1'b0, 1'b0, 32'h5555_5555, "R5 not stored");
    run_op(3'd2, 32'hAAAA_5555, 32'hFFFF_0000, 1'b0, 1'b1, 32'h5555_5555, "R3 stored after clean");
  endtask

  task automatic t_hit_error();
    run_op(3'd2, 32'hAAAA_5555, 32'hFFFF_0000, 1'b1, 1'b1, 32'h5555_5555, "R6 hit masks error");
  endtask

  task automatic t_exact();
    run_op(3'd2, 32'hAAAA_5554, 32'hFFFF_0000, 1'b0, 1'b0, 32'h5555_5554, "R7 bit0 differs");
  endtask

  task automatic t_approx();
    logic [31:0] base = model(3'd0, 32'h4000_0000, 32'h0000_2000);
    cfg_write(1'b1);
    run_op(3'd0, 32'h4000_0000, 32'h0000_2000, 1'b0, 1'b0, base, "R8 approx fill");
    run_op(3'd0, 32'h4000_0FFF, 32'h0000_2800, 1'b0, 1'b1, base, "R8 low bits ignored");
    run_op(3'd0, 32'h4000_1000, 32'h0000_2000, 1'b0, 1'b0, 32'h4000_3000, "R8 bit12 differs");
    run_op(3'd3, 32'h4000_0000, 32'h0000_2000, 1'b0, 1'b0, 32'h0, "R8 opcode differs");
  endtask

  task automatic t_flush();
    cfg_write(1'b1);
    run_op(3'd0, 32'h4000_0000, 32'h0000_2000, 1'b0, 1'b0, 32'h4000_2000, "R10 flushed entry misses");
  endtask

  task automatic t_fifo();
    cfg_write(1'b0);
    for (int i = 0; i < 5; i++)
      run_op(3'(i), 32'h0100_0000 * (i + 1), 32'h0000_0003, 1'b0, 1'b0,
             model(3'(i), 32'h0100_0000 * (i + 1), 32'h0000_0003), "R9 fill");
    for (int i = 1; i < 5; i++)
      run_op(3'(i), 32'h0100_0000 * (i + 1), 32'h0000_0003, 1'b0, 1'b1,
             model(3'(i), 32'h0100_0000 * (i + 1), 32'h0000_0003), "R9 newest four kept");
    run_op(3'd0, 32'h0100_0000, 32'h0000_0003, 1'b0, 1'b0, 32'h0100_0003, "R9 oldest evicted");
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; iss_valid = 1'b0; iss_op = '0; iss_a = '0; iss_b = '0;
    pipe_err = 1'b0; cfg_we = 1'b0; cfg_wdata = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_miss_then_hit();
    t_miss_error();
    t_hit_error();
    t_exact();
    t_approx();
    t_flush();
    t_fifo();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule